// File: doc/BRIEF.md
# Vertical Sync Detector with Timeout

This block watches an active-low composite sync level that has already been sliced to a clean digital signal, and it marks the start of each vertical interval with an active-low vertical sync pulse. The input arrives from outside the clock domain, so it first passes through a short synchroniser chain. After that the block measures how long each low period lasts, in clock cycles.

Short lows are horizontal syncs or narrow equalising pulses, and they are ignored. A low that lasts at least the broad threshold is a serration. The rising edge that ends it starts the vertical pulse. If the input stays low long enough to reach the default delay, the pulse is forced out at that moment instead, which covers non-standard video that has no serrations. Once a pulse has fired, a lockout window keeps the rest of the vertical interval from firing again.

All widths and thresholds are parameters counted in system clock cycles.

Top module: `vsync_detect`

## Requirements
- R1: `vsync_no` is high out of reset and whenever no pulse is active. Asserting `rst_ni` low forces it high at once, without waiting for a clock edge, and clears the lockout.
- R2: A low period on `csync_ni` shorter than `BROAD_CYC` cycles never starts a vertical pulse. This covers horizontal syncs and equalising pulses.
- R3: When a low period of at least `BROAD_CYC` and fewer than `DEFAULT_CYC` cycles ends with a rising edge, `vsync_no` goes low. It does so after the third rising clock edge that follows the input change, which is two synchroniser stages plus one output register.
- R4: When `csync_ni` stays low for `DEFAULT_CYC` consecutive sampled cycles, a default pulse starts without waiting for the rising edge. The rising edge that later ends such a low does not fire.
- R5: Every vertical pulse holds `vsync_no` low for exactly `WIDTH_CYC` clock cycles.
- R6: After a pulse fires, triggers at the next `LOCK_CYC` clock edges are ignored (`LOCK_CYC >= WIDTH_CYC`). A trigger at the edge after that fires again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csync_ni | input | 1 | Sliced composite sync, active low, not yet synchronised |
| vsync_no | output | 1 | Vertical sync pulse, active low; its falling edge marks the vertical start |

## Verification
A broad-pulse trigger shows at `vsync_no` after the third rising edge following the input change. A default trigger shows `DEFAULT_CYC + 2` edges after the first edge that samples the low level. The pulse then stays low for exactly `WIDTH_CYC` cycles. The bench reference model keeps a history queue of the sampled input. It reads the entry two edges old, applies the low-length rules to it, and updates its expected output at the same edge as the design. The bench compares 1 ns after every rising edge, so each result is checked in the cycle it is due. Separate per-phase counts of falling edges and a width measure of each pulse check R2 to R6 without relying on the model.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  typedef enum logic [1:0] {
    TRIG_NONE    = 2'd0,
    TRIG_BROAD   = 2'd1,
    TRIG_DEFAULT = 2'd2
  } trig_e;
endpackage

// File: rtl/vsd_sync.sv
module vsd_sync #(
  parameter int  STAGES    = 2,
  parameter bit  RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q[i] <= RESET_VAL;
      else if (i == 0) ff_q[i] <= d_i;
      else ff_q[i] <= ff_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/vsd_low_timer.sv
module vsd_low_timer
  import vsd_pkg::*;
#(
  parameter int BROAD_CYC   = 540,
  parameter int DEFAULT_CYC = 1620
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lvl_i,
  output trig_e trig_o
);
  localparam int CW = $clog2(DEFAULT_CYC + 1);
  localparam logic [CW-1:0] BROAD_C = CW'(BROAD_CYC);
  localparam logic [CW-1:0] DEF_C   = CW'(DEFAULT_CYC);
  localparam logic [CW-1:0] DEF_M1  = CW'(DEFAULT_CYC - 1);

  // consecutive low samples, saturating at DEFAULT_CYC
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (lvl_i) run_q <= '0;
    else if (run_q != DEF_C) run_q <= run_q + 1'b1;
  end

  always_comb begin
    trig_o = TRIG_NONE;
    if (lvl_i && run_q >= BROAD_C && run_q < DEF_C) trig_o = TRIG_BROAD;
    else if (!lvl_i && run_q == DEF_M1) trig_o = TRIG_DEFAULT;
  end
endmodule

// File: rtl/vsd_pulse_gen.sv
module vsd_pulse_gen #(
  parameter int WIDTH_CYC = 7290,
  parameter int LOCK_CYC  = 17160
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic vsync_no
);
  localparam int WW = $clog2(WIDTH_CYC + 1);
  localparam int LW = $clog2(LOCK_CYC + 1);

  logic [WW-1:0] vs_q;
  logic [LW-1:0] lock_q;
  logic          fire;

  assign fire = trig_i && (lock_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q   <= '0;
      lock_q <= '0;
    end else if (fire) begin
      vs_q   <= WW'(WIDTH_CYC);
      lock_q <= LW'(LOCK_CYC);
    end else begin
      if (vs_q != '0)   vs_q   <= vs_q - 1'b1;
      if (lock_q != '0) lock_q <= lock_q - 1'b1;
    end
  end

  assign vsync_no = (vs_q == '0);
endmodule

// File: rtl/vsync_detect.sv
module vsync_detect
  import vsd_pkg::*;
#(
  parameter int BROAD_CYC   = 540,
  parameter int DEFAULT_CYC = 1620,
  parameter int WIDTH_CYC   = 7290,
  parameter int LOCK_CYC    = 17160,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csync_ni,
  output logic vsync_no
);
  logic  lvl_sync;
  trig_e trig_kind;
  logic  trig_any;

  vsd_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (csync_ni),
    .q_o   (lvl_sync)
  );

  vsd_low_timer #(.BROAD_CYC(BROAD_CYC), .DEFAULT_CYC(DEFAULT_CYC)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl_sync),
    .trig_o(trig_kind)
  );

  assign trig_any = (trig_kind != TRIG_NONE);

  vsd_pulse_gen #(.WIDTH_CYC(WIDTH_CYC), .LOCK_CYC(LOCK_CYC)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (trig_any),
    .vsync_no(vsync_no)
  );
endmodule

// File: rtl/vsync_detect_chk.sv
module vsync_detect_chk #(
  parameter int WIDTH_CYC = 7290,
  parameter int LOCK_CYC  = 17160
) (
  input logic clk_i,
  input logic rst_ni,
  input logic vsync_no,
  input logic trig_i
);
  localparam int CW = $clog2(WIDTH_CYC + 2);
  localparam int GW = $clog2(LOCK_CYC + 1);

  logic [CW-1:0] low_len;
  logic [GW-1:0] gap;
  logic          vs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_len <= '0;
      gap     <= GW'(LOCK_CYC);
      vs_d    <= 1'b1;
    end else begin
      vs_d    <= vsync_no;
      low_len <= vsync_no ? '0 : low_len + 1'b1;
      if (vs_d && !vsync_no) gap <= GW'(1);
      else if (gap != GW'(LOCK_CYC)) gap <= gap + 1'b1;
    end
  end

  assert_pulse_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_no) |-> low_len == CW'(WIDTH_CYC));

  assert_lockout_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vsync_no) |-> $past(gap) == GW'(LOCK_CYC));

  assert_fall_has_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vsync_no) |-> $past(trig_i));

  assert_armed_fires_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && vsync_no && gap == GW'(LOCK_CYC)) |=> !vsync_no);
endmodule

bind vsync_detect vsync_detect_chk #(.WIDTH_CYC(WIDTH_CYC), .LOCK_CYC(LOCK_CYC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .vsync_no(vsync_no),
  .trig_i  (trig_any)
);

// File: tb/vsync_detect_tb.sv
`timescale 1ns/1ps
module vsync_detect_tb;
  localparam int BROAD = 20;
  localparam int DEFC  = 60;
  localparam int WID   = 40;
  localparam int LOCK  = 200;
  localparam int SYNC  = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic csync_ni = 1'b1;
  logic vsync_no;

  int n_cmp = 0;
  int n_bad = 0;
  int falls = 0;
  int low_len = 0;
  bit prev_vs = 1'b1;
  bit exp_vs = 1'b1;
  bit hist[$];
  int run = 0;
  int vs_left = 0;
  int lock_left = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  vsync_detect #(
    .BROAD_CYC(BROAD), .DEFAULT_CYC(DEFC), .WIDTH_CYC(WID),
    .LOCK_CYC(LOCK), .SYNC_STAGES(SYNC)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .csync_ni(csync_ni), .vsync_no(vsync_no)
  );

  // reference model, advanced per rising edge, compared 1 ns later
  always @(posedge clk) begin
    if (!rst_ni) begin
      hist.delete();
      run = 0; vs_left = 0; lock_left = 0; exp_vs = 1'b1;
    end else begin
      bit x, trig, fire;
      hist.push_back(csync_ni);
      if (hist.size() > 8) void'(hist.pop_front());
      x = (hist.size() > SYNC) ? hist[hist.size()-1-SYNC] : 1'b1;
      trig = (x && run >= BROAD && run < DEFC) || (!x && run == DEFC-1);
      run = x ? 0 : ((run < DEFC) ? run + 1 : DEFC);
      fire = trig && lock_left == 0;
      if (fire) begin vs_left = WID; lock_left = LOCK; end
      else begin
        if (vs_left > 0) vs_left--;
        if (lock_left > 0) lock_left--;
      end
      exp_vs = (vs_left == 0);
    end
    #1;
    n_cmp++;
    if (vsync_no !== exp_vs) begin
      n_bad++;
      $display("FAIL %s model: vsync_no=%0b expected %0b at %0t", phase, vsync_no, exp_vs, $time);
    end
    if (!rst_ni) begin
      prev_vs = 1'b1; low_len = 0;
    end else begin
      if (prev_vs && !vsync_no) falls++;
      if (!prev_vs && vsync_no) begin
        n_cmp++;
        if (low_len != WID) begin
          n_bad++;
          $display("FAIL R5 width: low for %0d expected %0d", low_len, WID);
        end
      end
      low_len = vsync_no ? 0 : low_len + 1;
      prev_vs = vsync_no;
    end
  end

  task automatic seg(bit v, int n);
    csync_ni = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(int lo, int hi, int reps);
    for (int i = 0; i < reps; i++) begin
      seg(1'b0, lo);
      seg(1'b1, hi);
    end
  endtask

  task automatic expect_falls(int base, int want, string req);
    n_cmp++;
    if (falls - base != want) begin
      n_bad++;
      $display("FAIL %s: %0d pulses expected %0d", req, falls - base, want);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
  end

  initial begin
    int b;
    repeat (4) @(negedge clk);
    n_cmp++;
    if (vsync_no !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 reset: vsync_no=%0b expected 1", vsync_no);
    end
    rst_ni = 1'b1;
    seg(1'b1, 10);

    phase = "R2"; b = falls;
    pulses(5, 95, 3);
    pulses(19, 30, 2);
    expect_falls(b, 0, "R2 narrow lows");

    phase = "R3"; b = falls;
    pulses(3, 45, 6);
    pulses(30, 5, 5);
    pulses(3, 45, 6);
    expect_falls(b, 1, "R3 first serration");

    phase = "R3"; b = falls;
    seg(1'b1, 20);
    pulses(20, 30, 1);
    expect_falls(b, 1, "R3 threshold low");
    phase = "R6"; b = falls;
    pulses(25, 10, 4);
    expect_falls(b, 0, "R6 lockout ignores serrations");
    seg(1'b1, 300);

    phase = "R4"; b = falls;
    pulses(100, 300, 1);
    expect_falls(b, 1, "R4 long low default");
    b = falls;
    pulses(60, 300, 1);
    expect_falls(b, 1, "R4 exact default length");
    b = falls;
    pulses(59, 300, 1);
    expect_falls(b, 1, "R4 one short of default, R3 edge");

    phase = "R6"; b = falls;
    pulses(30, 220, 2);
    expect_falls(b, 2, "R6 rearm after lockout");

    phase = "R1"; b = falls;
    pulses(30, 10, 1);
    expect_falls(b, 1, "R1 pulse before reset");
    rst_ni = 1'b0;
    #1;
    n_cmp++;
    if (vsync_no !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 async reset: vsync_no=%0b expected 1", vsync_no);
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    seg(1'b1, 5);
    b = falls;
    pulses(30, 20, 1);
    expect_falls(b, 1, "R1 reset clears lockout");
    seg(1'b1, 60);
    summary();
  end
endmodule